// File: doc/BRIEF.md
# Panel Data Pin Packer

This block sits at the tail of a display pipeline. It receives already-dithered pixels, one per cycle on each of two half-screen streams, and collects their bits into parallel words for the panel data pins. It raises a valid strobe for one cycle with each finished word. In a monochrome mode each pixel is a single bit, and each active pin carries one pixel per word. In the colour mode each pixel has three one-bit components. Those components fill the 8-pin word in order, and a pixel that does not fit finishes in the next word, so 8 pixels take exactly 3 words.

With the dual-panel switch set, a second pin group of the same width drives the lower half of the screen. A word is released only when both groups are complete, so the two halves always leave together. A line-end flag on the last pixel of a line pads the open word with zeros. The next line then starts at pin 0 of a fresh word.

Top module: `pdp_packer`

## Requirements
- R1: After reset, pin_valid is 0, and up_ready is 1 from the first cycle after reset is released.
- R2: With cfg_mode=0 (4-pin monochrome, one pixel per pin) and no dual panel, each word holds 4 pixels taken from bit 0 of the pixel input. The first pixel is on pin 0, and pin_data[15:4] is 0.
- R3: With cfg_mode=1 (8-pin monochrome) and no dual panel, each word holds 8 one-bit pixels, the earliest on pin 0. pin_data[15:8] is 0.
- R4: With cfg_mode=2 (8-pin colour), each pixel adds three components in the order bit 0 (red), bit 1 (green), bit 2 (blue) to the next free pins, starting at pin 0. A component that does not fit goes to the next word. Eight pixels of value 1 give the words 0x49, 0x92, 0x24.
- R5: With cfg_dual=1, the lower-half group occupies the pins just above the upper-half group. That means bits [7:4] in 4-pin mode and bits [15:8] in the 8-pin modes. Each group is filled only from its own stream.
- R6: No word is sent until every active group is full, or is closed by a line end. A stream whose group is complete deasserts its ready until the word leaves.
- R7: A pixel accepted with its last flag set closes the open word. The unused pins are padded with 0, and the next pixel starts at pin 0 of a new word.
- R8: With cfg_dual=0, lo_ready stays 0, and the lower-half stream has no effect on pin_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-side clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0: 4-pin mono, 1: 8-pin mono, 2: 8-pin colour, 3: as 1 |
| cfg_dual | input | 1 | 1 enables the lower-half pin group |
| up_valid | input | 1 | Upper-half pixel present |
| up_ready | output | 1 | Upper-half pixel taken this cycle when valid |
| up_data | input | 3 | Upper-half pixel; bit 0 only in mono modes |
| up_last | input | 1 | Upper-half pixel ends a line |
| lo_valid | input | 1 | Lower-half pixel present |
| lo_ready | output | 1 | Lower-half pixel taken this cycle when valid |
| lo_data | input | 3 | Lower-half pixel; bit 0 only in mono modes |
| lo_last | input | 1 | Lower-half pixel ends a line |
| pin_data | output | 16 | Packed panel pin word |
| pin_valid | output | 1 | pin_data holds a new word this cycle |

## Verification
The assertions assume that cfg_mode and cfg_dual change only while reset is held. The fill bound and the flush behaviour depend on one fixed group width and pixel width. The bench therefore applies reset before each configuration and holds both settings steady for the whole run. It keeps a pixel and its last flag unchanged until the handshake completes. It also drives the lower stream with traffic in single-panel runs, so that the idle group is exercised without breaking these assumptions.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  parameter int unsigned GRP_W   = 8;
  parameter int unsigned COMP_W  = 3;
  parameter int unsigned NUM_GRP = 2;
  localparam int unsigned PIN_W  = GRP_W * NUM_GRP;
  localparam int unsigned ACC_W  = GRP_W + COMP_W - 1;
  localparam int unsigned CNT_W  = $clog2(ACC_W + 1);

  typedef enum logic [1:0] {
    MODE_MONO4 = 2'd0,
    MODE_MONO8 = 2'd1,
    MODE_RGB8  = 2'd2,
    MODE_ALT8  = 2'd3
  } pin_mode_e;
endpackage

// File: rtl/pdp_lane.sv
module pdp_lane
  import pdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  grp_w,
  input  logic [CNT_W-1:0]  pix_w,
  input  logic              in_valid,
  input  logic [COMP_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              word_rdy,
  output logic [GRP_W-1:0]  word,
  input  logic              pop
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flush_q, flush_d;
  logic [ACC_W-1:0] pix_ext;
  logic [GRP_W-1:0] grp_mask;
  logic             take, upd;

  always_comb begin
    word_rdy = (cnt_q >= grp_w) || (flush_q && (cnt_q != '0));
    in_ready = en && !word_rdy && !flush_q;
    take     = in_valid && in_ready;
    upd      = take || pop;
    pix_ext  = ACC_W'(in_data) & ((ACC_W'(1) << pix_w) - ACC_W'(1));
    grp_mask = GRP_W'((ACC_W'(1) << grp_w) - ACC_W'(1));
    word     = acc_q[GRP_W-1:0] & grp_mask;
  end

  always_comb begin
    acc_d   = acc_q;
    cnt_d   = cnt_q;
    flush_d = flush_q;
    if (pop) begin
      acc_d = acc_q >> grp_w;
      if (cnt_q > grp_w) begin
        cnt_d = cnt_q - grp_w;
      end else begin
        cnt_d   = '0;
        flush_d = 1'b0;
      end
    end else if (take) begin
      acc_d = acc_q | (pix_ext << cnt_q);
      cnt_d = cnt_q + pix_w;
      if (in_last) flush_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      cnt_q   <= '0;
      flush_q <= 1'b0;
    end else if (upd) begin
      acc_q   <= acc_d;
      cnt_q   <= cnt_d;
      flush_q <= flush_d;
    end
  end

  // R4: carried bits never exceed one word plus a partial pixel
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= grp_w + pix_w - CNT_W'(1));

  // R6: the merger only takes a word this lane reports as complete
  assert_pop_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> word_rdy);

  // R7: a line end always leaves a word ready to go
  assert_line_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> word_rdy);
endmodule

// File: rtl/pdp_merge.sv
module pdp_merge
  import pdp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dual,
  input  logic [CNT_W-1:0] grp_w,
  input  logic             rdy_up,
  input  logic             rdy_lo,
  input  logic [GRP_W-1:0] word_up,
  input  logic [GRP_W-1:0] word_lo,
  output logic             pop_up,
  output logic             pop_lo,
  output logic [PIN_W-1:0] pin_data,
  output logic             pin_valid
);
  logic             emit;
  logic [PIN_W-1:0] frame;
  logic [PIN_W-1:0] data_q;
  logic             valid_q;

  always_comb begin
    emit   = rdy_up && (!dual || rdy_lo);
    pop_up = emit;
    pop_lo = emit && dual;
    frame  = PIN_W'(word_up);
    if (dual) frame = frame | (PIN_W'(word_lo) << grp_w);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= emit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (emit) data_q <= frame;
  end

  assign pin_data  = data_q;
  assign pin_valid = valid_q;

  // R6: an unfinished lower group in dual mode blocks the next word
  assert_dual_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && !rdy_lo) |=> !pin_valid);
endmodule

// File: rtl/pdp_packer.sv
module pdp_packer
  import pdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_dual,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [COMP_W-1:0] up_data,
  input  logic              up_last,
  input  logic              lo_valid,
  output logic              lo_ready,
  input  logic [COMP_W-1:0] lo_data,
  input  logic              lo_last,
  output logic [PIN_W-1:0]  pin_data,
  output logic              pin_valid
);
  pin_mode_e        mode;
  logic [CNT_W-1:0] grp_w, pix_w;
  logic             ln_en    [NUM_GRP];
  logic             ln_valid [NUM_GRP];
  logic [COMP_W-1:0] ln_data [NUM_GRP];
  logic             ln_last  [NUM_GRP];
  logic             ln_ready [NUM_GRP];
  logic             ln_wrdy  [NUM_GRP];
  logic [GRP_W-1:0] ln_word  [NUM_GRP];
  logic             ln_pop   [NUM_GRP];

  always_comb begin
    mode  = pin_mode_e'(cfg_mode);
    grp_w = (mode == MODE_MONO4) ? CNT_W'(GRP_W / 2) : CNT_W'(GRP_W);
    pix_w = (mode == MODE_RGB8)  ? CNT_W'(COMP_W)    : CNT_W'(1);
    ln_en[0] = 1'b1;       ln_en[1] = cfg_dual;
    ln_valid[0] = up_valid; ln_valid[1] = lo_valid;
    ln_data[0]  = up_data;  ln_data[1]  = lo_data;
    ln_last[0]  = up_last;  ln_last[1]  = lo_last;
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_lane
    pdp_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ln_en[g]),
      .grp_w    (grp_w),
      .pix_w    (pix_w),
      .in_valid (ln_valid[g]),
      .in_data  (ln_data[g]),
      .in_last  (ln_last[g]),
      .in_ready (ln_ready[g]),
      .word_rdy (ln_wrdy[g]),
      .word     (ln_word[g]),
      .pop      (ln_pop[g])
    );
  end

  pdp_merge u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .dual      (cfg_dual),
    .grp_w     (grp_w),
    .rdy_up    (ln_wrdy[0]),
    .rdy_lo    (ln_wrdy[1]),
    .word_up   (ln_word[0]),
    .word_lo   (ln_word[1]),
    .pop_up    (ln_pop[0]),
    .pop_lo    (ln_pop[1]),
    .pin_data  (pin_data),
    .pin_valid (pin_valid)
  );

  assign up_ready = ln_ready[0];
  assign lo_ready = ln_ready[1];

  // R8: the lower stream is never accepted in single-panel mode
  assert_lower_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dual |-> !lo_ready);

  // R2: 4-pin single-panel words leave the upper pins clear
  assert_mono4_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_valid && (cfg_mode == 2'd0) && !cfg_dual) |-> (pin_data[PIN_W-1:GRP_W/2] == '0));
endmodule

// File: tb/sim_pdp_packer.sv
module sim_pdp_packer;
  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_mode;
  logic        cfg_dual;
  logic        up_valid, up_last, lo_valid, lo_last;
  logic [2:0]  up_data, lo_data;
  logic        up_ready, lo_ready;
  logic [15:0] pin_data;
  logic        pin_valid;

  int total = 0;
  int bad   = 0;
  bit q0[$];
  bit q1[$];
  bit flp[2];
  bit exp_v;
  logic [15:0] exp_d;
  logic [15:0] got[$];
  int gw, nb;
  bit dual;
  string tag;

  pdp_packer u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dual(cfg_dual),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data), .up_last(up_last),
    .lo_valid(lo_valid), .lo_ready(lo_ready), .lo_data(lo_data), .lo_last(lo_last),
    .pin_data(pin_data), .pin_valid(pin_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int qsize(input int l);
    return (l == 0) ? q0.size() : q1.size();
  endfunction

  function automatic bit m_wrdy(input int l);
    return (qsize(l) >= gw) || (flp[l] && qsize(l) > 0);
  endfunction

  function automatic bit m_rdy(input int l);
    bit en;
    en = (l == 0) || dual;
    return en && !m_wrdy(l) && !flp[l];
  endfunction

  task automatic do_reset(input int mode, input bit d);
    cfg_mode = 2'(mode);
    cfg_dual = d;
    dual = d;
    gw = (mode == 0) ? 4 : 8;
    nb = (mode == 2) ? 3 : 1;
    tag = d ? "R5" : (mode == 0) ? "R2" : (mode == 2) ? "R4" : "R3";
    up_valid = 0; lo_valid = 0; up_data = 0; lo_data = 0; up_last = 0; lo_last = 0;
    rst_n = 0;
    q0.delete(); q1.delete(); flp[0] = 0; flp[1] = 0; exp_v = 0; exp_d = 0;
    got.delete();
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic step(input bit v0, input logic [2:0] d0, input bit l0,
                      input bit v1, input logic [2:0] d1, input bit l1,
                      output bit a0, output bit a1);
    bit em;
    logic [15:0] w;
    @(negedge clk);
    up_valid = v0; up_data = d0; up_last = l0;
    lo_valid = v1; lo_data = d1; lo_last = l1;
    #1;
    chk(up_ready == m_rdy(0), "R6", "up_ready", int'(up_ready), int'(m_rdy(0)));
    chk(lo_ready == m_rdy(1), dual ? "R6" : "R8", "lo_ready", int'(lo_ready), int'(m_rdy(1)));
    chk(pin_valid == exp_v, "R6", "pin_valid", int'(pin_valid), int'(exp_v));
    if (exp_v && pin_valid) begin
      chk(pin_data == exp_d, tag, "pin_data", int'(pin_data), int'(exp_d));
      got.push_back(pin_data);
    end
    a0 = v0 && m_rdy(0);
    a1 = v1 && m_rdy(1);
    em = m_wrdy(0) && (!dual || m_wrdy(1));
    exp_v = em;
    if (em) begin
      w = '0;
      for (int i = 0; i < gw; i++) if (q0.size() > 0) w[i] = q0.pop_front();
      if (q0.size() == 0) flp[0] = 0;
      if (dual) begin
        for (int i = 0; i < gw; i++) if (q1.size() > 0) w[gw + i] = q1.pop_front();
        if (q1.size() == 0) flp[1] = 0;
      end
      exp_d = w;
    end
    if (a0) begin
      for (int i = 0; i < nb; i++) q0.push_back(d0[i]);
      if (l0) flp[0] = 1;
    end
    if (a1) begin
      for (int i = 0; i < nb; i++) q1.push_back(d1[i]);
      if (l1) flp[1] = 1;
    end
  endtask

  task automatic idle(input int n);
    bit a0, a1;
    for (int i = 0; i < n; i++) step(0, 3'd0, 0, 0, 3'd0, 0, a0, a1);
  endtask

  task automatic sendpix(input int l, input logic [2:0] d, input bit last);
    bit a0, a1;
    do step(l == 0, d, last, l == 1, d, last, a0, a1);
    while (!((l == 0) ? a0 : a1));
  endtask

  task automatic rand_run(input int n);
    bit p0, p1, a0, a1, l0, l1;
    logic [2:0] d0, d1;
    p0 = 0; p1 = 0; d0 = 0; d1 = 0; l0 = 0; l1 = 0;
    for (int i = 0; i < n; i++) begin
      if (!p0 && ($urandom % 10) < 7) begin p0 = 1; d0 = 3'($urandom); l0 = ($urandom % 9) == 0; end
      if (!p1 && ($urandom % 10) < 7) begin p1 = 1; d1 = 3'($urandom); l1 = ($urandom % 9) == 0; end
      step(p0, d0, l0, p1, d1, l1, a0, a1);
      if (a0) p0 = 0;
      if (a1) p1 = 0;
    end
    idle(8);
  endtask

  initial begin
    #(20 * 200000);
    chk(0, "WD", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a0, a1;
    // R1: reset state
    do_reset(1, 0);
    @(negedge clk); #1;
    chk(pin_valid == 0, "R1", "pin_valid after reset", int'(pin_valid), 0);
    chk(up_ready == 1, "R1", "up_ready after reset", int'(up_ready), 1);
    chk(lo_ready == 0, "R8", "lo_ready single", int'(lo_ready), 0);

    // R4: straddling colour components
    do_reset(2, 0);
    for (int i = 0; i < 8; i++) sendpix(0, 3'b001, i == 7);
    idle(6);
    chk(got.size() == 3, "R4", "colour word count", got.size(), 3);
    if (got.size() == 3) begin
      chk(got[0] == 16'h0049, "R4", "colour word0", int'(got[0]), 'h49);
      chk(got[1] == 16'h0092, "R4", "colour word1", int'(got[1]), 'h92);
      chk(got[2] == 16'h0024, "R4", "colour word2", int'(got[2]), 'h24);
    end

    // R7: line end pads and restarts at pin 0
    do_reset(1, 0);
    for (int i = 0; i < 3; i++) sendpix(0, 3'b001, i == 2);
    for (int i = 0; i < 8; i++) sendpix(0, (i == 0) ? 3'b001 : 3'b000, i == 7);
    idle(5);
    chk(got.size() == 2, "R7", "flush word count", got.size(), 2);
    if (got.size() == 2) begin
      chk(got[0] == 16'h0007, "R7", "padded word", int'(got[0]), 'h07);
      chk(got[1] == 16'h0001, "R7", "next line word", int'(got[1]), 'h01);
    end

    // R6: upper half alone cannot release a dual word
    do_reset(1, 1);
    for (int i = 0; i < 12; i++) step(1, 3'b001, 0, 0, 3'd0, 0, a0, a1);
    chk(got.size() == 0, "R6", "words while lower empty", got.size(), 0);
    chk(up_ready == 0, "R6", "up_ready when group full", int'(up_ready), 0);
    for (int i = 0; i < 8; i++) sendpix(1, 3'(i % 2), 0);
    idle(4);
    chk(got.size() == 1, "R6", "word after lower fills", got.size(), 1);
    if (got.size() >= 1) chk(got[0] == 16'hAAFF, "R5", "dual mono8 word", int'(got[0]), 'hAAFF);

    // R5: dual 4-pin group placement
    do_reset(0, 1);
    for (int i = 0; i < 4; i++) sendpix(0, (i == 0) ? 3'b001 : 3'b000, 0);
    for (int i = 0; i < 4; i++) sendpix(1, (i == 3) ? 3'b001 : 3'b000, 0);
    idle(4);
    chk(got.size() == 1, "R5", "dual mono4 count", got.size(), 1);
    if (got.size() >= 1) chk(got[0] == 16'h0081, "R5", "dual mono4 word", int'(got[0]), 'h81);

    // R2 R3 R4 R5 R8: random traffic in every configuration
    for (int m = 0; m < 3; m++) begin
      for (int d = 0; d < 2; d++) begin
        do_reset(m, d[0]);
        rand_run(300);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule